// File: doc/BRIEF.md
# Register Hazard Stall Tracker

This block keeps the hazard timing of one storage element, for example a single architectural register, inside a cycle-level pipeline timing model. It holds two scheduled times, both counted in cycles from the present: the furthest pending read and the furthest pending write. An elapsed-time input moves both times towards zero. Read and write requests each name a future cycle. The block classifies the request against the pending times, works out how many stall cycles the pipeline must take, moves the request to its legal time and records the outcome.

Four hazard kinds are recognised. A read that lands before the furthest pending read is counted as read-after-read but never stalls. A read that lands at or before the furthest pending write stalls until just after that write. A write is first held behind the pending write and then, from its possibly moved time, behind the pending read. Every nonzero stall is reported on a registered stall output and added to saturating per-kind and total counters.

Within one cycle the elapsed time is applied first, then the read, then the write. Both scheduled times are held in TW bits and stop at their largest value.

Top module: `hazard_tracker`

## Requirements
- R1: After reset both scheduled times, the stall output and every counter are zero.
- R2: A tick of N lowers both scheduled times by N, each stopping at zero.
- R3: A request whose time offset is zero is ignored: no counter, time or stall changes because of it.
- R4: A read at time t with t below the (ticked) read time increments the read-after-read count and adds no stall.
- R5: A read at time t with t at or below the write time stalls by (write time − t + 1), increments the read-after-write count, adds the stall to its stall count, and takes effective time write time + 1.
- R6: After a read the read time becomes the larger of its old value and the read's effective time.
- R7: A write at time t with t at or below the write time stalls by (write time − t + 1), increments the write-after-write count and its stall count, and moves t to write time + 1; this test comes before the read test.
- R8: The moved write time is then tested against the read time the same way (write-after-read count and stall count), and the write time becomes the larger of its old value and the effective write time.
- R9: In the cycle after a request, stall_len equals the sum of all stalls that cycle, stall_req is high exactly when it is nonzero, and the sum is added to the total stall count.
- R10: Every counter saturates at its largest value.
- R11: In one cycle the tick is applied first, then the read, then the write, which sees the read's updated time.
- R12: A scheduled time that would exceed 2^TW−1 is held at 2^TW−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Apply elapsed time this cycle |
| tick_amt | input | TW | Elapsed cycles |
| rd_en | input | 1 | Read request |
| rd_time | input | TW | Read time offset, must be nonzero |
| wr_en | input | 1 | Write request |
| wr_time | input | TW | Write time offset, must be nonzero |
| sched_rd | output | TW | Furthest scheduled read time |
| sched_wr | output | TW | Furthest scheduled write time |
| stall_req | output | 1 | Stall requested to the pipeline |
| stall_len | output | TW+2 | Stall cycles requested |
| rar_cnt | output | CW | Read-after-read events |
| raw_cnt | output | CW | Read-after-write events |
| raw_stall_cnt | output | CW | Stall cycles from read-after-write |
| waw_cnt | output | CW | Write-after-write events |
| waw_stall_cnt | output | CW | Stall cycles from write-after-write |
| war_cnt | output | CW | Write-after-read events |
| war_stall_cnt | output | CW | Stall cycles from write-after-read |
| stall_total | output | CW | All stall cycles |

## Verification
The assertions assume that a caller keeps the tick and both requests in one cycle meaningful: a zero offset means no request, and CW is at least TW+2 so one cycle's stall fits a counter step. The stimulus draws tick amounts and offsets from the full TW range including zero, mixes ticks with reads and writes in the same cycle, and runs long enough to drive every counter and both scheduled times into saturation, so the monotonic and ordering properties are exercised at their limits.

// File: rtl/hazard_tracker.sv
module hazard_tracker #(
  parameter int TW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [TW-1:0] tick_amt,
  input  logic          rd_en,
  input  logic [TW-1:0] rd_time,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_time,
  output logic [TW-1:0] sched_rd,
  output logic [TW-1:0] sched_wr,
  output logic          stall_req,
  output logic [TW+1:0] stall_len,
  output logic [CW-1:0] rar_cnt,
  output logic [CW-1:0] raw_cnt,
  output logic [CW-1:0] raw_stall_cnt,
  output logic [CW-1:0] waw_cnt,
  output logic [CW-1:0] waw_stall_cnt,
  output logic [CW-1:0] war_cnt,
  output logic [CW-1:0] war_stall_cnt,
  output logic [CW-1:0] stall_total
);
  localparam int E = TW + 2;
  localparam logic [E-1:0] TMAX = E'((1 << TW) - 1);
  localparam logic [E-1:0] ONE  = E'(1);

  logic [E-1:0] nr0, nw0, nr1, nw1, rt, wt, reff, wt1, wt2, rs, ws1, ws2, cyc;
  logic rd_go, wr_go, rar, raw, waw, war;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [E-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + (CW+1)'(b);
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  function automatic logic [E-1:0] clamp_max(input logic [E-1:0] a, input logic [E-1:0] b);
    logic [E-1:0] m;
    m = (a > b) ? a : b;
    return (m > TMAX) ? TMAX : m;
  endfunction

  assign rt    = E'(rd_time);
  assign wt    = E'(wr_time);
  assign rd_go = rd_en && (rd_time != '0);
  assign wr_go = wr_en && (wr_time != '0);

  always_comb begin
    nr0 = E'(sched_rd);
    nw0 = E'(sched_wr);
    if (tick_en) begin
      nr0 = (nr0 > E'(tick_amt)) ? nr0 - E'(tick_amt) : '0;
      nw0 = (nw0 > E'(tick_amt)) ? nw0 - E'(tick_amt) : '0;
    end
    rar  = rd_go && (rt < nr0);
    raw  = rd_go && (rt <= nw0);
    rs   = raw ? nw0 - rt + ONE : '0;
    reff = raw ? nw0 + ONE : rt;
    nr1  = rd_go ? clamp_max(nr0, reff) : nr0;
    waw  = wr_go && (wt <= nw0);
    ws1  = waw ? nw0 - wt + ONE : '0;
    wt1  = waw ? nw0 + ONE : wt;
    war  = wr_go && (wt1 <= nr1);
    ws2  = war ? nr1 - wt1 + ONE : '0;
    wt2  = war ? nr1 + ONE : wt1;
    nw1  = wr_go ? clamp_max(nw0, wt2) : nw0;
    cyc  = rs + ws1 + ws2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched_rd <= '0;  sched_wr <= '0;
      stall_req <= 1'b0; stall_len <= '0;
      rar_cnt <= '0; raw_cnt <= '0; raw_stall_cnt <= '0;
      waw_cnt <= '0; waw_stall_cnt <= '0;
      war_cnt <= '0; war_stall_cnt <= '0; stall_total <= '0;
    end else begin
      sched_rd  <= nr1[TW-1:0];
      sched_wr  <= nw1[TW-1:0];
      stall_req <= (cyc != '0);
      stall_len <= cyc;
      rar_cnt       <= sat_add(rar_cnt, E'(rar));
      raw_cnt       <= sat_add(raw_cnt, E'(raw));
      raw_stall_cnt <= sat_add(raw_stall_cnt, rs);
      waw_cnt       <= sat_add(waw_cnt, E'(waw));
      waw_stall_cnt <= sat_add(waw_stall_cnt, ws1);
      war_cnt       <= sat_add(war_cnt, E'(war));
      war_stall_cnt <= sat_add(war_stall_cnt, ws2);
      stall_total   <= sat_add(stall_total, cyc);
    end
  end

  // R3: no request and no tick leaves the block idle
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !rd_go && !wr_go) |=> ($stable(sched_rd) && $stable(sched_wr) && !stall_req));

  // R2: a tick at least as large as both times clears them when nothing else arrives
  p_tick_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !rd_go && !wr_go && tick_amt >= sched_rd && tick_amt >= sched_wr)
    |=> (sched_rd == '0 && sched_wr == '0));

  // R6: without a tick the scheduled times never move backwards
  p_sched_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (sched_rd >= $past(sched_rd) && sched_wr >= $past(sched_wr)));

  // R8: a write always lands after every pending read unless the time is clamped
  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !rd_go && !tick_en) |=> (sched_wr > sched_rd || E'(sched_wr) == TMAX));

  // R5: a lone read beyond the pending write causes no stall
  p_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !wr_go && !tick_en && rd_time > sched_wr) |=> (stall_len == '0));

  // R10: counters never decrease
  p_counter_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stall_total >= $past(stall_total) && rar_cnt >= $past(rar_cnt)
              && raw_cnt >= $past(raw_cnt) && waw_cnt >= $past(waw_cnt)
              && war_cnt >= $past(war_cnt)));
endmodule

// File: tb/hazard_tracker_test.sv
`timescale 1ns/1ps
module hazard_tracker_test;
  localparam int TW = 4;
  localparam int CW = 6;
  localparam int TM = (1 << TW) - 1;
  localparam int CM = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [TW-1:0] tick_amt = '0, rd_time = '0, wr_time = '0;
  logic [TW-1:0] sched_rd, sched_wr;
  logic stall_req;
  logic [TW+1:0] stall_len;
  logic [CW-1:0] rar_cnt, raw_cnt, raw_stall_cnt, waw_cnt, waw_stall_cnt,
                 war_cnt, war_stall_cnt, stall_total;

  always #2.5 clk = ~clk;

  hazard_tracker #(.TW(TW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_amt(tick_amt),
    .rd_en(rd_en), .rd_time(rd_time), .wr_en(wr_en), .wr_time(wr_time),
    .sched_rd(sched_rd), .sched_wr(sched_wr), .stall_req(stall_req),
    .stall_len(stall_len), .rar_cnt(rar_cnt), .raw_cnt(raw_cnt),
    .raw_stall_cnt(raw_stall_cnt), .waw_cnt(waw_cnt), .waw_stall_cnt(waw_stall_cnt),
    .war_cnt(war_cnt), .war_stall_cnt(war_stall_cnt), .stall_total(stall_total));

  int checks = 0, errors = 0;
  bit done = 0;
  int m_nr, m_nw, m_stall;
  int m_rar, m_raw, m_raws, m_waw, m_waws, m_war, m_wars, m_tot;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int a, int b);
    return (a + b > CM) ? CM : a + b;
  endfunction

  function automatic int lim(int a, int b);
    int m = (a > b) ? a : b;
    return (m > TM) ? TM : m;
  endfunction

  task automatic model_reset();
    m_nr = 0; m_nw = 0; m_stall = 0;
    m_rar = 0; m_raw = 0; m_raws = 0; m_waw = 0; m_waws = 0;
    m_war = 0; m_wars = 0; m_tot = 0;
  endtask

  task automatic model(bit te, int ta, bit re, int rt, bit we, int wt);
    int rs = 0, s1 = 0, s2 = 0, eff;
    if (te) begin
      m_nr = (m_nr > ta) ? m_nr - ta : 0;
      m_nw = (m_nw > ta) ? m_nw - ta : 0;
    end
    if (re && rt != 0) begin
      eff = rt;
      if (rt < m_nr) m_rar = sat(m_rar, 1);
      if (rt <= m_nw) begin
        rs = m_nw - rt + 1; eff = m_nw + 1;
        m_raw = sat(m_raw, 1); m_raws = sat(m_raws, rs);
      end
      m_nr = lim(m_nr, eff);
    end
    if (we && wt != 0) begin
      eff = wt;
      if (eff <= m_nw) begin
        s1 = m_nw - eff + 1; eff = m_nw + 1;
        m_waw = sat(m_waw, 1); m_waws = sat(m_waws, s1);
      end
      if (eff <= m_nr) begin
        s2 = m_nr - eff + 1; eff = m_nr + 1;
        m_war = sat(m_war, 1); m_wars = sat(m_wars, s2);
      end
      m_nw = lim(m_nw, eff);
    end
    m_stall = rs + s1 + s2;
    m_tot = sat(m_tot, m_stall);
  endtask

  task automatic compare_all();
    chk("R6 sched_rd", sched_rd, m_nr);
    chk("R8 sched_wr", sched_wr, m_nw);
    chk("R9 stall_len", stall_len, m_stall);
    chk("R9 stall_req", stall_req, m_stall != 0);
    chk("R4 rar_cnt", rar_cnt, m_rar);
    chk("R5 raw_cnt", raw_cnt, m_raw);
    chk("R5 raw_stall_cnt", raw_stall_cnt, m_raws);
    chk("R7 waw_cnt", waw_cnt, m_waw);
    chk("R7 waw_stall_cnt", waw_stall_cnt, m_waws);
    chk("R8 war_cnt", war_cnt, m_war);
    chk("R8 war_stall_cnt", war_stall_cnt, m_wars);
    chk("R9 stall_total", stall_total, m_tot);
  endtask

  task automatic step(bit te, int ta, bit re, int rt, bit we, int wt);
    tick_en = te; tick_amt = TW'(ta); rd_en = re; rd_time = TW'(rt);
    wr_en = we; wr_time = TW'(wt);
    model(te, ta, re, rt, we, wt);
    @(posedge clk); @(negedge clk);
    tick_en = 0; rd_en = 0; wr_en = 0;
    compare_all();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    compare_all();
    chk("R1 sched_rd reset", sched_rd, 0);
    chk("R1 stall_total reset", stall_total, 0);

    step(0,0, 0,0, 1,3);
    chk("R8 plain write sets time", sched_wr, 3);
    step(0,0, 1,2, 0,0);
    chk("R5 read behind write stalls", stall_len, 2);
    chk("R6 read effective time", sched_rd, 4);
    step(1,1, 0,0, 0,0);
    chk("R2 tick lowers read", sched_rd, 3);
    chk("R2 tick lowers write", sched_wr, 2);
    step(1,9, 0,0, 0,0);
    chk("R2 tick floors at zero", sched_rd + sched_wr, 0);
    step(0,0, 1,0, 1,0);
    chk("R3 zero offset ignored", stall_total, 2);
    chk("R3 zero offset no stall", stall_req, 0);
    step(0,0, 1,5, 0,0);
    step(0,0, 1,3, 0,0);
    chk("R4 rar counted", rar_cnt, 1);
    chk("R4 rar no stall", stall_len, 0);
    step(0,0, 0,0, 1,2);
    chk("R8 war stall", stall_len, 4);
    chk("R8 write moved past read", sched_wr, 6);
    step(0,0, 0,0, 1,4);
    chk("R7 waw stall", stall_len, 3);
    chk("R7 write time", sched_wr, 7);
    step(0,0, 1,7, 1,1);
    chk("R11 read then write stall", stall_len, 9);
    chk("R11 write sees read time", sched_wr, 9);
    step(0,0, 1,15, 0,0);
    step(0,0, 0,0, 1,15);
    chk("R12 write time clamps", sched_wr, TM);

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      step(k < 4, $urandom_range(0, TM), k > 2, $urandom_range(0, TM),
           k[0] || k > 7, $urandom_range(0, TM));
    end
    chk("R10 total saturates", stall_total, CM);
    chk("R10 raw saturates", raw_cnt, CM);

    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    model_reset();
    chk("R1 counters cleared", war_cnt + waw_cnt + rar_cnt, 0);
    compare_all();

    for (int t = 0; t <= TM; t++)
      for (int r = 0; r <= TM; r++)
        step(t[0], t, 1, r, 1, (r * 7 + t) % (TM + 1));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule